// File: doc/BRIEF.md
# Phase Comparator with Divided-Oscillator Counter and Lock Monitor

This block sits in the digital part of a frequency-synthesis loop. A programmable counter divides an incoming oscillator event stream by a divisor N. The divided stream is then compared in phase and frequency against a reference event stream. The comparison drives a three-state pump command, encoded as an enable plus a direction bit. When the enable is low, the pin is released (high impedance) because the two streams are in phase. When the enable is high, the direction bit says whether the divided stream is running ahead (high) or behind (low).

Software writes a new divisor at any time. The counter keeps running on the old value through the rest of the current reference period and through one further full reference period. The new value takes effect only after that. A lock monitor judges each reference period as a whole: it raises an unlock flag if any comparator pulse in that period was wide enough to pass the selectable dead zone. A separate validity output tells the controller when the flag can be trusted after a divisor change. All event inputs are single-cycle strobes that are synchronous to the block clock.

Top module: `phcmp_lock`

## Requirements
- R1: Each `vco_tick` advances the N counter. The tick that completes every N-th count produces a one-cycle `fb_tick` on the next cycle, and the counter restarts from zero.
- R2: A divisor written as 0 is stored and used as 1, so that every `vco_tick` produces an `fb_tick`.
- R3: A written divisor shows on `div_active` and takes effect only at the second `ref_tick` after the write, and the N counter restarts from zero on that tick. A write that coincides with a `ref_tick`, or that arrives while an earlier write is still waiting, starts the wait again.
- R4: When a divided pulse arrives while no reference pulse is pending, the comparator drives high: `pump_en`=1 and `pump_up`=1.
- R5: When a reference pulse arrives while no divided pulse is pending, the comparator drives low: `pump_en`=1 and `pump_up`=0.
- R6: When the two pulses reach the comparator in the same cycle, or the second one arrives, the comparator returns to the released state: `pump_en`=0 and `pump_up`=0.
- R7: With dead-zone setting `dz_sel`=d (0 to 3), `pump_en` rises only once an error pulse has already lasted d cycles. Shorter pulses never drive the output.
- R8: On each `ref_tick`, `unlock` is updated on the next cycle. It becomes 1 if `pump_en` was high in any cycle of the period that ends with that tick, and 0 otherwise.
- R9: `unlock_valid` drops on the cycle after a divisor write. It rises after the third `ref_tick` following the last write, and after reset it rises after the second `ref_tick`.
- R10: Reset (active-low `rst_n`) clears `fb_tick`, `pump_en`, `pump_up`, `unlock` and `unlock_valid`, and loads `div_active` with the default divisor 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_tick | input | 1 | One-cycle strobe per oscillator event |
| ref_tick | input | 1 | One-cycle strobe per reference period boundary |
| div_wr | input | 1 | Divisor write strobe |
| div_val | input | 12 | Divisor value written with `div_wr` |
| dz_sel | input | 2 | Dead-zone width in cycles |
| fb_tick | output | 1 | Divided oscillator strobe |
| div_active | output | 12 | Divisor currently used by the counter |
| pump_en | output | 1 | Pump drive enable; 0 means released |
| pump_up | output | 1 | Pump direction when enabled: 1 high, 0 low |
| unlock | output | 1 | Loss-of-lock flag for the last reference period |
| unlock_valid | output | 1 | Unlock flag is meaningful |

## Verification
The bench targets the reload boundary. A design that applied a divisor at the first reference tick would show the new value one period early. A design that did not restart the wait on a rewrite would apply a stale value. Coincident divided and reference pulses must leave the output released; a comparator that set one side before clearing would emit one-cycle glitches and falsely report unlock. The widest dead-zone setting is probed cycle by cycle, which exposes an off-by-one in the width counter. Locked and mismatched tick ratios show whether the unlock flag follows whole reference periods and whether validity waits the full three ticks after a write.

// File: rtl/phcmp_pkg.sv
package phcmp_pkg;
    typedef enum logic [1:0] {
        RLD_IDLE  = 2'd0,
        RLD_ARMED = 2'd1,
        RLD_HOLD  = 2'd2
    } reload_st_e;

    localparam int unsigned VALID_WAIT_WR  = 3;
    localparam int unsigned VALID_WAIT_RST = 2;
endpackage

// File: rtl/phcmp_ndiv.sv
module phcmp_ndiv
    import phcmp_pkg::*;
#(
    parameter int unsigned NW      = 12,
    parameter int unsigned RST_DIV = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vco_tick,
    input  logic          ref_tick,
    input  logic          div_wr,
    input  logic [NW-1:0] div_val,
    output logic          fb_tick,
    output logic [NW-1:0] div_active
);
    localparam logic [NW-1:0] DIV_RST = NW'(RST_DIV);
    localparam logic [NW-1:0] DIV_MIN = NW'(1);

    typedef struct packed {
        logic [NW-1:0] cnt;
        logic [NW-1:0] act;
        logic [NW-1:0] pend;
        reload_st_e    st;
        logic          fb;
    } ndiv_st_t;

    ndiv_st_t s_d, s_q;
    logic [NW:0] cnt_inc;

    always_comb begin
        s_d     = s_q;
        s_d.fb  = 1'b0;
        cnt_inc = {1'b0, s_q.cnt} + (NW+1)'(1);
        if (vco_tick) begin
            if (cnt_inc >= {1'b0, s_q.act}) begin
                s_d.cnt = '0;
                s_d.fb  = 1'b1;
            end else begin
                s_d.cnt = cnt_inc[NW-1:0];
            end
        end
        if (ref_tick) begin
            unique case (s_q.st)
                RLD_ARMED: s_d.st = RLD_HOLD;
                RLD_HOLD: begin
                    s_d.act = s_q.pend;
                    s_d.cnt = '0;
                    s_d.st  = RLD_IDLE;
                end
                default: s_d.st = s_q.st;
            endcase
        end
        if (div_wr) begin
            s_d.pend = (div_val == '0) ? DIV_MIN : div_val;
            s_d.st   = RLD_ARMED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt  <= '0;
            s_q.act  <= DIV_RST;
            s_q.pend <= DIV_RST;
            s_q.st   <= RLD_IDLE;
            s_q.fb   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fb_tick    = s_q.fb;
    assign div_active = s_q.act;
endmodule

// File: rtl/phcmp_pfd.sv
module phcmp_pfd #(
    parameter int unsigned DZW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fb_tick,
    input  logic           ref_tick,
    input  logic [DZW-1:0] dz_sel,
    output logic           pump_en,
    output logic           pump_up
);
    localparam logic [DZW-1:0] WID_MAX = '1;

    typedef struct packed {
        logic           ref_s;
        logic           hi;
        logic           lo;
        logic [DZW-1:0] wid;
    } pfd_st_t;

    pfd_st_t s_d, s_q;
    logic set_hi, set_lo, keep;

    always_comb begin
        s_d       = s_q;
        s_d.ref_s = ref_tick;
        set_hi    = s_q.hi | fb_tick;
        set_lo    = s_q.lo | s_q.ref_s;
        if (set_hi && set_lo) begin
            s_d.hi = 1'b0;
            s_d.lo = 1'b0;
        end else begin
            s_d.hi = set_hi;
            s_d.lo = set_lo;
        end
        keep = (s_d.hi && s_q.hi) || (s_d.lo && s_q.lo);
        if (!keep)
            s_d.wid = '0;
        else if (s_q.wid != WID_MAX)
            s_d.wid = s_q.wid + DZW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pump_en = (s_q.hi | s_q.lo) && (s_q.wid >= dz_sel);
    assign pump_up = pump_en & s_q.hi;
endmodule

// File: rtl/phcmp_lockdet.sv
module phcmp_lockdet
    import phcmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic div_wr,
    input  logic pump_en,
    output logic unlock,
    output logic unlock_valid
);
    typedef struct packed {
        logic       seen;
        logic       unl;
        logic [1:0] vwait;
    } lock_st_t;

    lock_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.seen = s_q.seen | pump_en;
        if (ref_tick) begin
            s_d.unl  = s_q.seen | pump_en;
            s_d.seen = 1'b0;
        end
        if (div_wr)
            s_d.vwait = 2'(VALID_WAIT_WR);
        else if (ref_tick && s_q.vwait != 2'd0)
            s_d.vwait = s_q.vwait - 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.seen  <= 1'b0;
            s_q.unl   <= 1'b0;
            s_q.vwait <= 2'(VALID_WAIT_RST);
        end else begin
            s_q <= s_d;
        end
    end

    assign unlock       = s_q.unl;
    assign unlock_valid = (s_q.vwait == 2'd0);
endmodule

// File: rtl/phcmp_lock.sv
module phcmp_lock #(
    parameter int unsigned NW      = 12,
    parameter int unsigned DZW     = 2,
    parameter int unsigned RST_DIV = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vco_tick,
    input  logic           ref_tick,
    input  logic           div_wr,
    input  logic [NW-1:0]  div_val,
    input  logic [DZW-1:0] dz_sel,
    output logic           fb_tick,
    output logic [NW-1:0]  div_active,
    output logic           pump_en,
    output logic           pump_up,
    output logic           unlock,
    output logic           unlock_valid
);
    logic fb_w, en_w;

    phcmp_ndiv #(.NW(NW), .RST_DIV(RST_DIV)) u_ndiv (
        .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .ref_tick(ref_tick),
        .div_wr(div_wr), .div_val(div_val), .fb_tick(fb_w), .div_active(div_active)
    );

    phcmp_pfd #(.DZW(DZW)) u_pfd (
        .clk(clk), .rst_n(rst_n), .fb_tick(fb_w), .ref_tick(ref_tick),
        .dz_sel(dz_sel), .pump_en(en_w), .pump_up(pump_up)
    );

    phcmp_lockdet u_lock (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .div_wr(div_wr),
        .pump_en(en_w), .unlock(unlock), .unlock_valid(unlock_valid)
    );

    assign fb_tick = fb_w;
    assign pump_en = en_w;
endmodule

// File: rtl/phcmp_lock_chk.sv
module phcmp_lock_chk #(
    parameter int unsigned NW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vco_tick,
    input logic          ref_tick,
    input logic          div_wr,
    input logic          fb_tick,
    input logic [NW-1:0] div_active,
    input logic          unlock,
    input logic          unlock_valid
);
    assert_fb_after_vco_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fb_tick |-> $past(vco_tick));

    assert_div_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_active) |-> $past(ref_tick));

    assert_unlock_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(unlock) |-> $past(ref_tick));

    assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> !unlock_valid);

    assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock_valid) |-> $past(ref_tick));
endmodule

bind phcmp_lock phcmp_lock_chk #(.NW(NW)) u_chk (
    .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .ref_tick(ref_tick),
    .div_wr(div_wr), .fb_tick(fb_tick), .div_active(div_active),
    .unlock(unlock), .unlock_valid(unlock_valid)
);

// File: tb/phcmp_lock_bench.sv
module phcmp_lock_bench;
    localparam int NW = 12;
    localparam int DZW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vco_tick = 1'b0, ref_tick = 1'b0, div_wr = 1'b0;
    logic [NW-1:0] div_val = '0;
    logic [DZW-1:0] dz_sel = '0;
    logic fb_tick, pump_en, pump_up, unlock, unlock_valid;
    logic [NW-1:0] div_active;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    phcmp_lock u_phcmp_lock (
        .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .ref_tick(ref_tick),
        .div_wr(div_wr), .div_val(div_val), .dz_sel(dz_sel), .fb_tick(fb_tick),
        .div_active(div_active), .pump_en(pump_en), .pump_up(pump_up),
        .unlock(unlock), .unlock_valid(unlock_valid)
    );

    // Expected-behaviour model built from the requirements
    int m_cnt, m_act, m_pend, m_st, m_wid, m_vw;
    bit m_fb, m_ref, m_hi, m_lo, m_seen, m_unl;

    function automatic bit exp_en(bit hi, bit lo, int wid, int dz);
        return (hi || lo) && (wid >= dz);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_act = 4; m_pend = 4; m_st = 0; m_fb = 0;
            m_ref = 0; m_hi = 0; m_lo = 0; m_wid = 0;
            m_seen = 0; m_unl = 0; m_vw = 2;
        end else begin
            bit en, sh, sl, nh, nl;
            int ncnt, nact, nst, nwid;
            en = exp_en(m_hi, m_lo, m_wid, int'(dz_sel));
            ncnt = m_cnt; nact = m_act; nst = m_st;
            if (vco_tick) ncnt = (m_cnt + 1 >= m_act) ? 0 : m_cnt + 1;
            if (ref_tick) begin
                if (m_st == 1) nst = 2;
                else if (m_st == 2) begin nact = m_pend; ncnt = 0; nst = 0; end
            end
            if (div_wr) begin m_pend = (div_val == 0) ? 1 : int'(div_val); nst = 1; end
            sh = m_hi | m_fb; sl = m_lo | m_ref;
            nh = sh & !(sh & sl); nl = sl & !(sh & sl);
            nwid = ((nh && m_hi) || (nl && m_lo)) ? ((m_wid < 3) ? m_wid + 1 : 3) : 0;
            m_fb = vco_tick && (m_cnt + 1 >= m_act);
            m_cnt = ncnt; m_act = nact; m_st = nst;
            m_hi = nh; m_lo = nl; m_wid = nwid; m_ref = ref_tick;
            if (ref_tick) begin m_unl = m_seen | en; m_seen = 0; end
            else m_seen = m_seen | en;
            if (div_wr) m_vw = 3;
            else if (ref_tick && m_vw != 0) m_vw = m_vw - 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            bit e_en;
            #5;
            e_en = exp_en(m_hi, m_lo, m_wid, int'(dz_sel));
            chk(fb_tick == m_fb, "R1 fb_tick", int'(fb_tick), int'(m_fb));
            chk(int'(div_active) == m_act, "R3 div_active", int'(div_active), m_act);
            chk(pump_en == e_en, "R7 pump_en", int'(pump_en), int'(e_en));
            chk(pump_up == (e_en & m_hi), "R4 pump_up", int'(pump_up), int'(e_en & m_hi));
            chk(unlock == m_unl, "R8 unlock", int'(unlock), int'(m_unl));
            chk(unlock_valid == (m_vw == 0), "R9 unlock_valid", int'(unlock_valid), int'(m_vw == 0));
        end
    end

    task automatic do_reset();
        vco_tick = 0; ref_tick = 0; div_wr = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic pulse_ref();
        ref_tick = 1; @(negedge clk); ref_tick = 0;
    endtask

    task automatic write_div(input int v);
        div_val = NW'(v); div_wr = 1; @(negedge clk); div_wr = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R10 reset state
        do_reset();
        chk(!pump_en && !pump_up && !fb_tick, "R10 outputs idle", int'(pump_en), 0);
        chk(!unlock && !unlock_valid, "R10 flags clear", int'(unlock_valid), 0);
        chk(div_active == 4, "R10 default divisor", int'(div_active), 4);

        // R1 / R4: four oscillator ticks, no reference
        for (int i = 0; i < 4; i++) begin vco_tick = 1; @(negedge clk); end
        vco_tick = 0;
        chk(fb_tick == 1, "R1 fourth tick divides", int'(fb_tick), 1);
        @(negedge clk);
        chk(pump_en && pump_up, "R4 drive high", int'(pump_up), 1);

        // R5: reference alone
        do_reset();
        pulse_ref(); @(negedge clk);
        chk(pump_en && !pump_up, "R5 drive low", int'(pump_en) * 2 + int'(pump_up), 2);

        // R7: widest dead zone
        do_reset(); dz_sel = 3;
        pulse_ref(); @(negedge clk); @(negedge clk); @(negedge clk);
        chk(!pump_en, "R7 inside dead zone", int'(pump_en), 0);
        @(negedge clk);
        chk(pump_en && !pump_up, "R7 past dead zone", int'(pump_en), 1);
        dz_sel = 0;

        // R6: coincident arrival
        do_reset();
        for (int i = 0; i < 4; i++) begin vco_tick = 1; ref_tick = (i == 3); @(negedge clk); end
        vco_tick = 0; ref_tick = 0;
        for (int i = 0; i < 3; i++) begin
            chk(!pump_en && !pump_up, "R6 released when aligned", int'(pump_en), 0);
            @(negedge clk);
        end

        // R3 / R9: deferred reload and validity
        do_reset();
        write_div(6);
        chk(!unlock_valid, "R9 invalid after write", int'(unlock_valid), 0);
        pulse_ref();
        chk(div_active == 4, "R3 old divisor kept", int'(div_active), 4);
        pulse_ref();
        chk(div_active == 6, "R3 new divisor applied", int'(div_active), 6);
        chk(!unlock_valid, "R9 still invalid", int'(unlock_valid), 0);
        pulse_ref();
        chk(unlock_valid, "R9 valid after third tick", int'(unlock_valid), 1);

        // R3 rewrite restarts the wait
        write_div(7); pulse_ref(); write_div(9); pulse_ref();
        chk(div_active == 6, "R3 rewrite restarts wait", int'(div_active), 6);
        pulse_ref();
        chk(div_active == 9, "R3 latest value applied", int'(div_active), 9);

        // R2: zero divisor
        write_div(0); pulse_ref(); pulse_ref();
        chk(div_active == 1, "R2 zero stored as one", int'(div_active), 1);
        vco_tick = 1; @(negedge clk); vco_tick = 0;
        chk(fb_tick == 1, "R2 every tick divides", int'(fb_tick), 1);

        // R8: locked then mismatched
        do_reset();
        for (int i = 0; i < 40; i++) begin vco_tick = 1; ref_tick = (i % 4 == 3); @(negedge clk); end
        chk(!unlock && unlock_valid, "R8 locked ratio", int'(unlock), 0);
        for (int i = 0; i < 40; i++) begin vco_tick = 1; ref_tick = (i % 5 == 4); @(negedge clk); end
        vco_tick = 0; ref_tick = 0;
        chk(unlock == 1, "R8 mismatched ratio", int'(unlock), 1);

        // Random segments checked each cycle against the model
        for (int seg = 0; seg < 6; seg++) begin
            int per, pct, ph;
            per = $urandom_range(30, 6);
            pct = (seg % 3 == 0) ? 100 : ((seg % 3 == 1) ? 50 : 25);
            dz_sel = DZW'($urandom_range(3, 0));
            ph = 0;
            for (int c = 0; c < 3000; c++) begin
                vco_tick = ($urandom_range(99, 0) < pct);
                ph++;
                ref_tick = (ph >= per);
                if (ref_tick) ph = 0;
                div_wr = ($urandom_range(199, 0) == 0);
                div_val = NW'($urandom_range(9, 0));
                @(negedge clk);
            end
            vco_tick = 0; ref_tick = 0; div_wr = 0;
        end

        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule